// File: doc/BRIEF.md
# I/O shadow register memory

This block sits between a simple synchronous system bus and a group of memory-mapped I/O device controllers. It decodes one address window and splits it into equal slots, one per device. Every write that lands in the window goes to the addressed device and, in the same cycle, to a shared RAM that keeps a copy of the written value. Device registers that hold static configuration can therefore be write-only, and software can still read them back.

On a read inside the window the block returns the stored copy from its shared RAM. The only exception is a device that raises its volatile flag for that access, such as a status or receive register that changes on its own. In that case the live device data is returned. Each device drives zero when it is not selected, so the block merges all device read buses with a bitwise OR and needs no read multiplexer. Read data is returned one cycle after the request, together with a valid strobe.

Top module: `io_shadow_mem`

## Requirements
- R1: While `bus_req_i` is high and the address lies inside the window (`bus_addr_i[15:8] == 8'hD0` by default), exactly one bit of `dev_cs_o` is set. Its index is `bus_addr_i[7:4]`, `dev_addr_o` equals `bus_addr_i[3:0]`, and `dev_we_o` follows `bus_we_i`.
- R2: A write inside the window stores `bus_wdata_i` in the shadow location for that address at the same clock edge, so a read in the very next cycle returns it.
- R3: A read inside the window with no volatile flag raised returns the shadow copy on `bus_rdata_o`, with `bus_rvalid_o` high, one cycle after the request. Device read data is ignored.
- R4: A read inside the window during which any bit of `dev_vol_i` is high returns, one cycle later, the device read data present in the request cycle instead of the shadow copy.
- R5: Device read data from all slots is merged by bitwise OR. Slot d drives bits `[8*d+7:8*d]` of `dev_rdata_i`.
- R6: An access outside the window asserts no chip select and no device write. It leaves the shadow contents unchanged and gives no `bus_rvalid_o`.
- R7: `bus_rdata_o` is zero in every cycle where `bus_rvalid_o` is low.
- R8: Every slot has its own shadow storage, so values written to the same register offset of different devices are kept apart.
- R9: During and right after reset, `bus_rvalid_o` is low, `bus_rdata_o` is zero and no chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_req_i | input | 1 | bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | byte address |
| bus_wdata_i | input | 8 | write data |
| bus_rvalid_o | output | 1 | read data valid, one cycle after a window read |
| bus_rdata_o | output | 8 | read data, zero when not valid |
| dev_cs_o | output | 16 | one-hot device select |
| dev_we_o | output | 1 | device write strobe |
| dev_addr_o | output | 4 | register offset inside the slot |
| dev_wdata_o | output | 8 | write data to devices |
| dev_rdata_i | input | 128 | packed device read data, 8 bits per slot |
| dev_vol_i | input | 16 | per-device volatile flag for the current access |

## Verification
Reads of registers on a slot that raises no volatile flag, while the device drives a fixed junk value, show whether the shadow source wins over the device bus. Reads of volatile registers whose device values change every cycle, repeated at different times, show whether live data is passed through and sampled in the request cycle rather than a cycle late. A write to an out-of-window address that aliases a window location in its low bits shows whether the decode guards the RAM. A sweep writing distinct values to one offset in every slot shows whether the slots stay apart. A deliberately overlapping drive from two devices confirms that the device data is merged by OR.

// File: rtl/io_shadow_pkg.sv
package io_shadow_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SHADOW = 2'd1,
    SRC_DEVICE = 2'd2
  } rd_src_e;
endpackage

// File: rtl/io_shadow_decode.sv
module io_shadow_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_AW = 8,
  parameter int unsigned SLOT_AW = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  localparam int unsigned NDEV = 2 ** (WIN_AW - SLOT_AW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic               wr_o,
  output logic               rd_o,
  output logic [NDEV-1:0]    cs_o,
  output logic [SLOT_AW-1:0] reg_o
);
  localparam int unsigned DEV_W = WIN_AW - SLOT_AW;

  logic [DEV_W-1:0] dev_idx;

  assign hit_o   = req_i && (addr_i[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign wr_o    = hit_o && we_i;
  assign rd_o    = hit_o && !we_i;
  assign dev_idx = addr_i[WIN_AW-1:SLOT_AW];
  assign reg_o   = addr_i[SLOT_AW-1:0];

  always_comb begin
    cs_o = '0;
    if (hit_o) cs_o[dev_idx] = 1'b1;
  end

  // R1: at most one device selected
  a_r1_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  // R1: a request in the window always selects a device
  a_r1_hit_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $countones(cs_o) == 1);
endmodule

// File: rtl/io_shadow_ram.sv
module io_shadow_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 2 ** AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // single port, synchronous read; contents undefined until written
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/io_shadow_rdsel.sv
module io_shadow_rdsel
  import io_shadow_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NDEV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [NDEV-1:0]  vol_i,
  input  logic [NDEV*DW-1:0] dev_rdata_i,
  input  logic [DW-1:0]    shadow_i,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] dev_or;
  logic          sys_vol;
  rd_src_e       src_q;
  logic [DW-1:0] dev_q;

  // wired-or of all device buses; unselected devices drive zero
  always_comb begin
    dev_or = '0;
    for (int d = 0; d < NDEV; d++) dev_or |= dev_rdata_i[d*DW +: DW];
  end

  assign sys_vol = |vol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_NONE;
      dev_q <= '0;
    end else begin
      if (!rd_i)        src_q <= SRC_NONE;
      else if (sys_vol) src_q <= SRC_DEVICE;
      else              src_q <= SRC_SHADOW;
      dev_q <= rd_i ? dev_or : '0;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_SHADOW: rdata_o = shadow_i;
      SRC_DEVICE: rdata_o = dev_q;
      default:    rdata_o = '0;
    endcase
  end

  assign rvalid_o = (src_q != SRC_NONE);

  // R7: idle bus reads as zero
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
  // R3: every window read produces a valid strobe next cycle
  a_r3_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  // R3: non-volatile read takes the RAM output
  a_r3_shadow_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sys_vol) |=> rdata_o == shadow_i);
endmodule

// File: rtl/io_shadow_mem.sv
module io_shadow_mem #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN_AW = 8,
  parameter int unsigned SLOT_AW = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  localparam int unsigned NDEV = 2 ** (WIN_AW - SLOT_AW)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic                   bus_rvalid_o,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic [NDEV-1:0]        dev_cs_o,
  output logic                   dev_we_o,
  output logic [SLOT_AW-1:0]     dev_addr_o,
  output logic [DATA_W-1:0]      dev_wdata_o,
  input  logic [NDEV*DATA_W-1:0] dev_rdata_i,
  input  logic [NDEV-1:0]        dev_vol_i
);
  logic              win_hit;
  logic              win_wr;
  logic              win_rd;
  logic [DATA_W-1:0] shadow_q;

  io_shadow_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_AW  (WIN_AW),
    .SLOT_AW (SLOT_AW),
    .WIN_BASE(WIN_BASE)
  ) u_decode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (bus_req_i),
    .we_i  (bus_we_i),
    .addr_i(bus_addr_i),
    .hit_o (win_hit),
    .wr_o  (win_wr),
    .rd_o  (win_rd),
    .cs_o  (dev_cs_o),
    .reg_o (dev_addr_o)
  );

  io_shadow_ram #(
    .AW(WIN_AW),
    .DW(DATA_W)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (win_wr),
    .re_i   (win_rd),
    .addr_i (bus_addr_i[WIN_AW-1:0]),
    .wdata_i(bus_wdata_i),
    .rdata_o(shadow_q)
  );

  io_shadow_rdsel #(
    .DW  (DATA_W),
    .NDEV(NDEV)
  ) u_rdsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (win_rd),
    .vol_i      (dev_vol_i),
    .dev_rdata_i(dev_rdata_i),
    .shadow_i   (shadow_q),
    .rvalid_o   (bus_rvalid_o),
    .rdata_o    (bus_rdata_o)
  );

  assign dev_we_o    = win_wr;
  assign dev_wdata_o = bus_wdata_i;

  // R6: out-of-window request selects nothing and yields no read
  a_r6_outside_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_addr_i[ADDR_W-1:WIN_AW] != WIN_BASE[ADDR_W-1:WIN_AW])
      |-> (dev_cs_o == '0 && !dev_we_o));
  a_r6_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit |=> !bus_rvalid_o);
  // R1: device write strobe only for a bus write
  a_r1_we_from_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_we_o |-> (bus_req_i && bus_we_i && dev_cs_o != '0));
endmodule

// File: tb/io_shadow_mem_tb.sv
module io_shadow_mem_tb;
  localparam int NDEV = 16;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            bus_req, bus_we;
  logic [15:0]     bus_addr;
  logic [7:0]      bus_wdata;
  logic            bus_rvalid;
  logic [7:0]      bus_rdata;
  logic [NDEV-1:0] dev_cs;
  logic            dev_we;
  logic [3:0]      dev_addr;
  logic [7:0]      dev_wdata;
  logic [NDEV*DW-1:0] dev_rdata;
  logic [NDEV-1:0] dev_vol;
  logic [7:0]      live = 8'h00;
  logic            or_extra = 1'b0;
  int              total = 0;
  int              bad = 0;

  always #5 clk = ~clk;

  io_shadow_mem u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rvalid_o(bus_rvalid),
    .bus_rdata_o (bus_rdata),
    .dev_cs_o    (dev_cs),
    .dev_we_o    (dev_we),
    .dev_addr_o  (dev_addr),
    .dev_wdata_o (dev_wdata),
    .dev_rdata_i (dev_rdata),
    .dev_vol_i   (dev_vol)
  );

  // free-running status source seen by the volatile registers
  always @(posedge clk) live <= live + 8'd7;

  // device models: slot 3 offsets 0..3 volatile, others drive junk 0xEE
  always_comb begin
    dev_rdata = '0;
    dev_vol = '0;
    for (int d = 0; d < NDEV; d++) begin
      if (dev_cs[d] && !bus_we) begin
        if (d == 3 && dev_addr[3:2] == 2'b00) begin
          dev_vol[d] = 1'b1;
          dev_rdata[d*DW +: DW] = or_extra ? 8'hF0 : (live ^ {d[3:0], dev_addr});
        end else begin
          dev_rdata[d*DW +: DW] = 8'hEE;
        end
      end
    end
    if (or_extra) dev_rdata[5*DW +: DW] = dev_rdata[5*DW +: DW] | 8'h0F;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // issues a read; returns live value seen in the request cycle plus result
  task automatic bus_read(input logic [15:0] a, output logic [7:0] live_seen,
                          output logic vld, output logic [7:0] data);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 live_seen = live;
    @(negedge clk);
    bus_req = 1'b0;
    vld = bus_rvalid; data = bus_rdata;
  endtask

  task automatic t_reset();
    check("R9 rvalid", 32'(bus_rvalid), 32'd0);
    check("R9 rdata", 32'(bus_rdata), 32'd0);
    check("R9 cs", 32'(dev_cs), 32'd0);
  endtask

  task automatic t_decode();
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'hD0A6; bus_wdata = 8'h3C;
    #1;
    check("R1 cs", 32'(dev_cs), 32'h0400);
    check("R1 offset", 32'(dev_addr), 32'h6);
    check("R1 we", 32'(dev_we), 32'd1);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_write_then_read();
    logic [7:0] l, d; logic v;
    bus_write(16'hD027, 8'hA5);
    bus_read(16'hD027, l, v, d);
    check("R2 valid", 32'(v), 32'd1);
    check("R2 data", 32'(d), 32'hA5);
    @(negedge clk);
    check("R7 idle rdata", 32'(bus_rdata), 32'd0);
  endtask

  task automatic t_nonvolatile();
    logic [7:0] l, d; logic v;
    bus_write(16'hD038, 8'h61);   // slot 3 offset 8: not volatile, device drives 0xEE
    bus_read(16'hD038, l, v, d);
    check("R3 shadow wins", 32'(d), 32'h61);
  endtask

  task automatic t_volatile();
    logic [7:0] l, d; logic v;
    bus_write(16'hD031, 8'h00);
    bus_read(16'hD031, l, v, d);
    check("R4 live a", 32'(d), 32'(l ^ 8'h31));
    repeat (3) @(negedge clk);
    bus_read(16'hD032, l, v, d);
    check("R4 live b", 32'(d), 32'(l ^ 8'h32));
  endtask

  task automatic t_or_merge();
    logic [7:0] l, d; logic v;
    or_extra = 1'b1;
    bus_read(16'hD030, l, v, d);
    or_extra = 1'b0;
    check("R5 or merge", 32'(d), 32'hFF);
  endtask

  task automatic t_outside();
    logic [7:0] l, d; logic v;
    bus_write(16'hD042, 8'h5A);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'hC042; bus_wdata = 8'h11;
    #1;
    check("R6 no cs", 32'({dev_cs, dev_we}), 32'd0);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    bus_read(16'hE142, l, v, d);
    check("R6 no rvalid", 32'(v), 32'd0);
    bus_read(16'hD042, l, v, d);
    check("R6 shadow kept", 32'(d), 32'h5A);
  endtask

  task automatic t_slots();
    logic [7:0] l, d; logic v;
    for (int s = 0; s < NDEV; s++) bus_write({8'hD0, 4'(s), 4'h9}, 8'(8'h80 + s * 3));
    for (int s = 0; s < NDEV; s++) begin
      bus_read({8'hD0, 4'(s), 4'h9}, l, v, d);
      check($sformatf("R8 slot %0d", s), 32'(d), 32'(8'h80 + s * 3));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_write_then_read();
    t_nonvolatile();
    t_volatile();
    t_or_merge();
    t_outside();
    t_slots();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule